// File: doc/BRIEF.md
# Quadratic-Congruence Hadamard Pulse Schedule Generator

This block produces the pulse-by-pulse schedule of a training sequence for an impulse radio link. Each sequence has L pulses. For every pulse it gives a time-hopping slot offset and a polarity. The slot offset follows a quadratic congruence modulo L. The polarity is read from one row of a Sylvester Hadamard matrix of order L+1. The same generator builds both beacon and frame training sequences. Different piconets are kept apart by choosing a different sequence number.

A start strobe captures the sequence number and the hop offset index, and presents pulse 0 on the next cycle. Each advance strobe then moves to the next pulse, until the final pulse has been consumed. The hop value is stepped with modular adders only. L is a parameter, and it must be a prime whose successor is a power of two (7, 31 or 127).

Top module: `qchp_preamble_gen`

## Requirements
- R1: While reset is high, and in the cycle after it, `valid` and `last` are 0.
- R2: A `start` sampled at a clock edge makes `valid` 1 after that edge, with pulse index k = 0. This holds even in the middle of a sequence, and `start` takes priority over `advance` in the same cycle.
- R3: For pulse k, `hop` equals (i·((k+n) mod L)²) mod L. Here i and n are the `seq_i` and `hop_n` values captured at start, each reduced mod L. `hop` is always below L.
- R4: For pulse k, `pol` equals the parity of the bitwise AND of `seq_i` and k+1. A value of 0 means positive polarity and 1 means negative polarity.
- R5: An `advance` sampled while `valid` is 1 moves to pulse k+1 after that edge. Without `advance`, `hop`, `pol` and `valid` hold.
- R6: `last` is 1 exactly while pulse k = L-1 is presented. An `advance` on that pulse clears `valid` after the edge.
- R7: An `advance` while `valid` is 0 has no effect, and `valid` stays 0.
- R8: A change of `seq_i` or `hop_n` after the start edge does not affect the running sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a sequence with the current seq_i and hop_n |
| advance | input | 1 | Consume the presented pulse and present the next |
| seq_i | input | LW | Sequence number, meaningful range 1 to L-1; also the Hadamard row |
| hop_n | input | LW | Hop offset index, 0 to L-1 (the value L is read as 0) |
| hop | output | LW | Time-hopping slot offset of the presented pulse |
| pol | output | 1 | Polarity of the presented pulse, 1 = negative |
| valid | output | 1 | A pulse is presented |
| last | output | 1 | The presented pulse is the final one, k = L-1 |

## Verification
The bench walks every pulse of several sequences. These include the largest sequence number and offset, and an offset equal to L. A wrong initial square or an off-by-one in the incremental step would show up as a mismatched hop part-way through. A wrong reduction of the offset L would give a non-zero first hop. The bench also restarts mid-sequence while asserting advance in the same cycle, which catches a design that resumes instead of restarting. Holding without advance, idle advances and input changes after start are all checked, to catch counters that drift or parameters that are sampled live. The final pulse is checked for a premature or missing last flag and for valid persisting past the end.

// File: rtl/qchp_pkg.sv
package qchp_pkg;

    localparam int MAX_BITS = 16;

    typedef struct packed {
        logic load;
        logic step;
    } seq_cmd_t;

    function automatic int unsigned mod_add(int unsigned a, int unsigned b, int unsigned m);
        int unsigned s;
        s = a + b;
        return (s >= m) ? s - m : s;
    endfunction

    function automatic int unsigned mod_red(int unsigned a, int unsigned m);
        return (a >= m) ? a - m : a;
    endfunction

    // shift-and-add modular product; operands already below m
    function automatic int unsigned mod_mul(int unsigned a, int unsigned b, int unsigned m);
        int unsigned acc;
        acc = 0;
        for (int j = MAX_BITS - 1; j >= 0; j--) begin
            acc = mod_add(acc, acc, m);
            if (b[j]) acc = mod_add(acc, a, m);
        end
        return acc;
    endfunction

endpackage

// File: rtl/qchp_seq_ctrl.sv
module qchp_seq_ctrl
    import qchp_pkg::*;
#(
    parameter int L  = 31,
    parameter int LW = $clog2(L + 1)
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     start,
    input  logic     advance,
    output seq_cmd_t cmd,
    output logic     valid,
    output logic     last
);
    localparam logic [LW-1:0] LAST_IDX = LW'(L - 1);

    logic          valid_q;
    logic [LW-1:0] idx_q;

    assign valid    = valid_q;
    assign last     = valid_q && (idx_q == LAST_IDX);
    assign cmd.load = start;
    assign cmd.step = advance && valid_q && !start;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            idx_q   <= '0;
        end else if (start) begin
            valid_q <= 1'b1;
            idx_q   <= '0;
        end else if (cmd.step) begin
            if (last) valid_q <= 1'b0;
            idx_q <= idx_q + 1'b1;
        end
    end

    assert_last_needs_valid_R6: assert property (@(posedge clk) disable iff (rst)
        last |-> valid);
    assert_end_drops_valid_R6: assert property (@(posedge clk) disable iff (rst)
        (last && advance && !start) |=> !valid);
    assert_start_restarts_R2: assert property (@(posedge clk) disable iff (rst)
        start |=> (valid && idx_q == '0));
    assert_idle_advance_R7: assert property (@(posedge clk) disable iff (rst)
        (!valid && !start) |=> !valid);
endmodule

// File: rtl/qchp_hop_stepper.sv
module qchp_hop_stepper
    import qchp_pkg::*;
#(
    parameter int L  = 31,
    parameter int LW = $clog2(L + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  seq_cmd_t      cmd,
    input  logic [LW-1:0] seq_i,
    input  logic [LW-1:0] hop_n,
    output logic [LW-1:0] hop
);
    localparam int unsigned M = L;

    logic [LW-1:0] hop_q, delta_q, twice_i_q;
    logic [LW-1:0] hop_init, delta_init, twice_i_init;

    // hop(m) = i*m^2, delta(m) = i*(2m+1), delta steps by 2i
    always_comb begin
        int unsigned ir, nr, nsq, odd;
        ir           = mod_red(32'(seq_i), M);
        nr           = mod_red(32'(hop_n), M);
        nsq          = mod_mul(nr, nr, M);
        odd          = mod_add(mod_add(nr, nr, M), 1, M);
        hop_init     = LW'(mod_mul(ir, nsq, M));
        delta_init   = LW'(mod_mul(ir, odd, M));
        twice_i_init = LW'(mod_add(ir, ir, M));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hop_q     <= '0;
            delta_q   <= '0;
            twice_i_q <= '0;
        end else if (cmd.load) begin
            hop_q     <= hop_init;
            delta_q   <= delta_init;
            twice_i_q <= twice_i_init;
        end else if (cmd.step) begin
            hop_q   <= LW'(mod_add(32'(hop_q), 32'(delta_q), M));
            delta_q <= LW'(mod_add(32'(delta_q), 32'(twice_i_q), M));
        end
    end

    assign hop = hop_q;

    assert_hop_in_range_R3: assert property (@(posedge clk) disable iff (rst)
        (32'(hop_q) < M) && (32'(delta_q) < M));
endmodule

// File: rtl/qchp_polarity.sv
module qchp_polarity
    import qchp_pkg::*;
#(
    parameter int L  = 31,
    parameter int LW = $clog2(L + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  seq_cmd_t      cmd,
    input  logic [LW-1:0] seq_i,
    output logic          pol
);
    logic [LW-1:0] row_q, col_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            row_q <= '0;
            col_q <= LW'(1);
        end else if (cmd.load) begin
            row_q <= seq_i;
            col_q <= LW'(1);
        end else if (cmd.step) begin
            col_q <= col_q + 1'b1;
        end
    end

    assign pol = ^(row_q & col_q);

    assert_row_held_R8: assert property (@(posedge clk) disable iff (rst)
        !cmd.load |=> $stable(row_q));
endmodule

// File: rtl/qchp_preamble_gen.sv
module qchp_preamble_gen
    import qchp_pkg::*;
#(
    parameter int L  = 31,
    parameter int LW = $clog2(L + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          advance,
    input  logic [LW-1:0] seq_i,
    input  logic [LW-1:0] hop_n,
    output logic [LW-1:0] hop,
    output logic          pol,
    output logic          valid,
    output logic          last
);
    seq_cmd_t cmd;

    initial begin
        assert_length_shape_R3: assert ((1 << LW) == L + 1 && L >= 3);
    end

    qchp_seq_ctrl #(.L(L), .LW(LW)) u_ctrl (
        .clk(clk), .rst(rst), .start(start), .advance(advance),
        .cmd(cmd), .valid(valid), .last(last)
    );

    qchp_hop_stepper #(.L(L), .LW(LW)) u_hop (
        .clk(clk), .rst(rst), .cmd(cmd), .seq_i(seq_i), .hop_n(hop_n), .hop(hop)
    );

    qchp_polarity #(.L(L), .LW(LW)) u_pol (
        .clk(clk), .rst(rst), .cmd(cmd), .seq_i(seq_i), .pol(pol)
    );

    assert_hold_without_advance_R5: assert property (@(posedge clk) disable iff (rst)
        (valid && !advance && !start) |=> (valid && $stable(hop) && $stable(pol)));
endmodule

// File: tb/sim_qchp_preamble_gen.sv
module sim_qchp_preamble_gen;
    localparam int L  = 31;
    localparam int LW = 5;
    localparam int NV = 6;
    // {seq_i, hop_n, expected hop of pulse 0}
    localparam logic [14:0] VEC [NV] = '{
        {5'd1,  5'd0,  5'd0},
        {5'd3,  5'd5,  5'd13},
        {5'd30, 5'd30, 5'd30},
        {5'd17, 5'd12, 5'd30},
        {5'd5,  5'd31, 5'd0},
        {5'd22, 5'd1,  5'd22}
    };

    logic clk = 0, rst = 1, start = 0, advance = 0;
    logic [LW-1:0] seq_i = '0, hop_n = '0, hop;
    logic pol, valid, last;
    int checks = 0, fails = 0;

    always #5 clk = ~clk;

    qchp_preamble_gen #(.L(L)) u0 (
        .clk(clk), .rst(rst), .start(start), .advance(advance),
        .seq_i(seq_i), .hop_n(hop_n), .hop(hop), .pol(pol), .valid(valid), .last(last)
    );

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_hop(int i, int n, int k);
        int m;
        m = (k + n) % L;
        return ((i % L) * m * m) % L;
    endfunction

    function automatic int exp_pol(int i, int k);
        return $countones(i & (k + 1)) % 2;
    endfunction

    task automatic report();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    task automatic begin_seq(int i, int n);
        seq_i = LW'(i); hop_n = LW'(n); start = 1;
        @(negedge clk);
        start = 0;
    endtask

    task automatic step();
        advance = 1;
        @(negedge clk);
        advance = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        report();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 valid in reset", int'(valid), 0);
        chk("R1 last in reset", int'(last), 0);
        rst = 0;
        @(negedge clk);
        chk("R1 valid after reset", int'(valid), 0);

        // R7: idle advance
        step();
        chk("R7 idle advance", int'(valid), 0);
        step();
        chk("R7 idle advance last", int'(last), 0);

        // table walk: R2 R3 R4 R5 R6
        for (int v = 0; v < NV; v++) begin
            int i, n;
            i = int'(VEC[v][14:10]);
            n = int'(VEC[v][9:5]);
            begin_seq(i, n);
            chk("R2 valid after start", int'(valid), 1);
            chk("R3 table first hop", int'(hop), int'(VEC[v][4:0]));
            for (int k = 0; k < L; k++) begin
                chk("R3 hop", int'(hop), exp_hop(i, n, k));
                chk("R4 pol", int'(pol), exp_pol(i, k));
                chk("R6 last", int'(last), (k == L - 1) ? 1 : 0);
                chk("R5 valid", int'(valid), 1);
                step();
            end
            chk("R6 valid after end", int'(valid), 0);
        end

        // R5: hold without advance
        begin_seq(3, 5);
        step(); step();
        repeat (3) @(negedge clk);
        chk("R5 hold hop", int'(hop), exp_hop(3, 5, 2));
        chk("R5 hold pol", int'(pol), exp_pol(3, 2));
        chk("R5 hold valid", int'(valid), 1);

        // R8: inputs change after start
        seq_i = 5'd9; hop_n = 5'd20;
        step();
        chk("R8 hop unaffected", int'(hop), exp_hop(3, 5, 3));
        chk("R8 pol unaffected", int'(pol), exp_pol(3, 3));

        // R2: restart with advance in the same cycle
        seq_i = 5'd7; hop_n = 5'd4; start = 1; advance = 1;
        @(negedge clk);
        start = 0; advance = 0;
        chk("R2 restart hop", int'(hop), exp_hop(7, 4, 0));
        chk("R2 restart pol", int'(pol), exp_pol(7, 0));
        chk("R2 restart last", int'(last), 0);
        step();
        chk("R2 restart second hop", int'(hop), exp_hop(7, 4, 1));

        // R1: reset during a run
        rst = 1;
        @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk("R1 reset mid run", int'(valid), 0);

        report();
        $finish;
    end
endmodule